// File: doc/BRIEF.md
# Mono Serial Audio Port

This block moves one mono audio channel across a serial bit-clocked link. On the receive side it captures a serial input line and hands each completed sample to the core as a parallel word with a single-cycle valid strobe. On the transmit side it takes a parallel sample from the core and shifts it out on a serial output line. Both directions send the most significant bit first. The whole block is clocked by the link's bit clock. The receive side captures on the rising edge and the transmit side launches on the falling edge.

A frame-sync input marks the start of every frame. A format selector picks one of five framings: right justified, left justified, I2S, PCM and PCM with a programmable time slot. The format sets which level of frame sync marks the active (left) half of the frame, and where the word sits inside that half. A word-length selector sets the sample size. Only the left slot carries data. Input bits in the right slot are discarded, and the output line is held low wherever no word is being sent.

Frame positions are counted in rising bit-clock edges. The rising edge that first samples frame sync at its active level, after having sampled it inactive, is position 0. Position p is the p-th rising edge after position 0.

Top module: `serial_audio_port`

## Requirements
- R1: While `rst` is high and right after its release, `rx_valid`, `tx_take` and `dout` are low. No frame starts until frame sync has been sampled at its inactive level at least once after reset.
- R2: `fmt_sel` codes are 0 right justified, 1 left justified, 2 I2S, 3 PCM and 4 PCM time slot. For codes 0 and 1 the active level of frame sync is high. For codes 2, 3 and 4 it is low.
- R3: `wlen_sel` codes 0, 1, 2 and 3 select 16, 20, 24 and 32 bit words. A received word is presented right aligned on `rx_data`, with zeros above the word. The low bits of `tx_data` are transmitted.
- R4: Each word is carried most significant bit first, in both directions.
- R5: In left justified and PCM formats the word starts at position 0. In I2S it starts at position 1.
- R6: In right justified format the word starts at L minus the word length. L is the number of active-level positions in the most recent complete active phase. The start is 0 when no active phase has ended since reset, or when L is smaller than the word length.
- R7: In PCM time-slot format the word starts at the position given by the 10-bit `slot_ofs`. The count runs from position 0 whatever level frame sync takes afterwards.
- R8: `din` is sampled on the rising edges at the word's positions. `rx_valid` is high for exactly one bit-clock cycle, starting at the rising edge that captures the last bit, with the word on `rx_data`.
- R9: `tx_take` is high for one bit-clock cycle, starting at the rising edge at the word's first position. `tx_data` is latched on the following falling edge. Bit k of the word (counting from the MSB) is driven on `dout` from the falling edge after the rising edge at first position + k.
- R10: Outside the word's positions, `din` has no effect (right-slot data is ignored) and `dout` is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame sync |
| din | input | 1 | Serial receive data |
| fmt_sel | input | 3 | Framing format code |
| wlen_sel | input | 2 | Word length code |
| slot_ofs | input | 10 | Word start position for time-slot format |
| tx_data | input | 32 | Parallel sample to transmit |
| tx_take | output | 1 | Strobe: `tx_data` is latched on the next falling edge |
| dout | output | 1 | Serial transmit data |
| rx_data | output | 32 | Last received sample, right aligned |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_data` |

## Verification
The bench drives right-justified framing first straight after reset, before any active phase has been measured, and then again once a measurement exists. A design that seeded the slot length wrongly would misalign the first word. It also runs right justified with a slot shorter than the word, where an offset that wraps would move the word hundreds of positions away. A time-slot offset larger than the active phase checks that the count keeps running after frame sync returns to its inactive level; a counter that stopped there would never reach the slot. The right slot is filled with ones throughout, so a port that let it leak in would corrupt received words or drive ones on an idle output line.

// File: rtl/sap_pkg.sv
package sap_pkg;

    localparam int DATA_W = 32;   // widest sample carried
    localparam int SLOT_W = 10;   // time-slot offset field
    localparam int POS_W  = 11;   // frame position counter
    localparam int WL_W   = 6;    // holds a bit count up to 32

    typedef enum logic [2:0] {
        FMT_RJ    = 3'd0,
        FMT_LJ    = 3'd1,
        FMT_I2S   = 3'd2,
        FMT_PCM   = 3'd3,
        FMT_TSLOT = 3'd4
    } fmt_e;

    typedef enum logic [1:0] {
        WL_16 = 2'd0,
        WL_20 = 2'd1,
        WL_24 = 2'd2,
        WL_32 = 2'd3
    } wl_e;

    typedef struct packed {
        logic in_win;   // current edge lies inside the word
        logic first;    // current edge carries the MSB
        logic last;     // current edge carries the LSB
    } slot_flags_t;

    function automatic logic [WL_W-1:0] wl_bits(input wl_e code);
        case (code)
            WL_16:   return WL_W'(16);
            WL_20:   return WL_W'(20);
            WL_24:   return WL_W'(24);
            default: return WL_W'(32);
        endcase
    endfunction

    function automatic logic fmt_active_high(input fmt_e f);
        return (f == FMT_RJ) || (f == FMT_LJ);
    endfunction

endpackage

// File: rtl/sap_frame_timer.sv
module sap_frame_timer
    import sap_pkg::*;
#(
    parameter int POS_BITS  = POS_W,
    parameter int SLOT_BITS = SLOT_W
) (
    input  logic                 bclk,
    input  logic                 rst,
    input  logic                 fsync,
    input  fmt_e                 fmt,
    input  logic [WL_W-1:0]      wl,
    input  logic [SLOT_BITS-1:0] slot,
    output slot_flags_t          now_f,
    output logic                 win_q,
    output logic                 first_q
);

    localparam logic [POS_BITS-1:0] POS_MAX = '1;
    localparam int                  EXT_W   = POS_BITS + 1;

    logic                act_now;
    logic                prev_act;
    logic                framed;
    logic                start;
    logic                live;
    logic [POS_BITS-1:0] pos_q;
    logic [POS_BITS-1:0] cur_pos;
    logic [POS_BITS-1:0] last_len;
    logic [POS_BITS-1:0] off;
    logic [POS_BITS-1:0] wl_ext;
    logic [EXT_W-1:0]    cur_x;
    logic [EXT_W-1:0]    off_x;
    logic [EXT_W-1:0]    end_x;

    assign act_now = fmt_active_high(fmt) ? fsync : ~fsync;
    assign start   = act_now & ~prev_act;
    assign live    = framed | start;
    assign cur_pos = start ? '0 : pos_q;
    assign wl_ext  = POS_BITS'(wl);

    // Word start position per format
    always_comb begin
        case (fmt)
            FMT_RJ:    off = (last_len >= wl_ext) ? (last_len - wl_ext) : '0;
            FMT_I2S:   off = POS_BITS'(1);
            FMT_TSLOT: off = POS_BITS'(slot);
            default:   off = '0;
        endcase
    end

    assign cur_x = {1'b0, cur_pos};
    assign off_x = {1'b0, off};
    assign end_x = off_x + {1'b0, wl_ext};

    always_comb begin
        now_f.in_win = live && (cur_x >= off_x) && (cur_x < end_x);
        now_f.first  = now_f.in_win && (cur_x == off_x);
        now_f.last   = now_f.in_win && (cur_x == (end_x - EXT_W'(1)));
    end

    always_ff @(posedge bclk) begin
        if (rst) begin
            prev_act <= 1'b1;
            framed   <= 1'b0;
            pos_q    <= '0;
            last_len <= '0;
            win_q    <= 1'b0;
            first_q  <= 1'b0;
        end else begin
            prev_act <= act_now;
            framed   <= live;
            pos_q    <= (cur_pos == POS_MAX) ? cur_pos : cur_pos + POS_BITS'(1);
            if (framed && prev_act && !act_now) begin
                last_len <= pos_q;
            end
            win_q    <= now_f.in_win;
            first_q  <= now_f.first;
        end
    end

endmodule

// File: rtl/sap_rx_deser.sv
module sap_rx_deser
    import sap_pkg::*;
#(
    parameter int WORD_W = DATA_W
) (
    input  logic              bclk,
    input  logic              rst,
    input  logic              din,
    input  slot_flags_t       now_f,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid
);

    logic [WORD_W-1:0] sh;

    always_ff @(posedge bclk) begin
        if (rst) begin
            sh       <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (now_f.first) begin
                sh <= {{(WORD_W-1){1'b0}}, din};
            end else if (now_f.in_win) begin
                sh <= {sh[WORD_W-2:0], din};
            end
            if (now_f.last) begin
                rx_data  <= {sh[WORD_W-2:0], din};
                rx_valid <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sap_tx_ser.sv
module sap_tx_ser
    import sap_pkg::*;
#(
    parameter int WORD_W = DATA_W
) (
    input  logic              bclk,
    input  logic              rst,
    input  logic              win_q,
    input  logic              first_q,
    input  logic [WL_W-1:0]   wl,
    input  logic [WORD_W-1:0] tx_data,
    output logic              dout
);

    localparam int SH_W = WL_W + 1;

    logic [WORD_W-1:0] sh;
    logic [WORD_W-1:0] aligned;
    logic [SH_W-1:0]   shamt;

    // Move the word's MSB to the top of the register
    assign shamt   = SH_W'(WORD_W) - SH_W'(wl);
    assign aligned = tx_data << shamt;

    always_ff @(negedge bclk) begin
        if (rst) begin
            sh   <= '0;
            dout <= 1'b0;
        end else if (first_q) begin
            dout <= aligned[WORD_W-1];
            sh   <= aligned << 1;
        end else if (win_q) begin
            dout <= sh[WORD_W-1];
            sh   <= sh << 1;
        end else begin
            dout <= 1'b0;
        end
    end

endmodule

// File: rtl/serial_audio_port.sv
module serial_audio_port
    import sap_pkg::*;
#(
    parameter int WORD_W    = DATA_W,
    parameter int SLOT_BITS = SLOT_W,
    parameter int POS_BITS  = POS_W
) (
    input  logic                 bclk,
    input  logic                 rst,
    input  logic                 fsync,
    input  logic                 din,
    input  logic [2:0]           fmt_sel,
    input  logic [1:0]           wlen_sel,
    input  logic [SLOT_BITS-1:0] slot_ofs,
    input  logic [WORD_W-1:0]    tx_data,
    output logic                 tx_take,
    output logic                 dout,
    output logic [WORD_W-1:0]    rx_data,
    output logic                 rx_valid
);

    fmt_e            fmt;
    logic [WL_W-1:0] wl;
    slot_flags_t     flags_now;
    logic            win_q;
    logic            first_q;

    assign fmt     = fmt_e'(fmt_sel);
    assign wl      = wl_bits(wl_e'(wlen_sel));
    assign tx_take = first_q;

    sap_frame_timer #(
        .POS_BITS  (POS_BITS),
        .SLOT_BITS (SLOT_BITS)
    ) timer_i (
        .bclk    (bclk),
        .rst     (rst),
        .fsync   (fsync),
        .fmt     (fmt),
        .wl      (wl),
        .slot    (slot_ofs),
        .now_f   (flags_now),
        .win_q   (win_q),
        .first_q (first_q)
    );

    sap_rx_deser #(
        .WORD_W (WORD_W)
    ) rx_i (
        .bclk     (bclk),
        .rst      (rst),
        .din      (din),
        .now_f    (flags_now),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

    sap_tx_ser #(
        .WORD_W (WORD_W)
    ) tx_i (
        .bclk    (bclk),
        .rst     (rst),
        .win_q   (win_q),
        .first_q (first_q),
        .wl      (wl),
        .tx_data (tx_data),
        .dout    (dout)
    );

endmodule

// File: rtl/sap_checker.sv
module sap_checker (
    input logic bclk,
    input logic rst,
    input logic rx_valid,
    input logic tx_take,
    input logic dout,
    input logic win_q
);

    // R8: a received word is flagged for a single cycle
    assert_valid_pulse_R8: assert property (@(posedge bclk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R8: the strobe only follows an edge inside the word
    assert_valid_in_window_R8: assert property (@(posedge bclk) disable iff (rst)
        rx_valid |-> win_q);

    // R9: the take strobe is one cycle wide
    assert_take_pulse_R9: assert property (@(posedge bclk) disable iff (rst)
        tx_take |=> !tx_take);

    // R9: the word keeps shifting after it is taken
    assert_take_then_shift_R9: assert property (@(posedge bclk) disable iff (rst)
        tx_take |=> win_q);

    // R10: the line idles low outside the word
    assert_idle_low_R10: assert property (@(negedge bclk) disable iff (rst)
        !win_q |=> !dout);

endmodule

bind serial_audio_port sap_checker chk_i (
    .bclk     (bclk),
    .rst      (rst),
    .rx_valid (rx_valid),
    .tx_take  (tx_take),
    .dout     (dout),
    .win_q    (win_q)
);

// File: tb/serial_audio_port_tb.sv
module serial_audio_port_tb_top;

    localparam int CLK_PERIOD = 20;
    localparam int MAXL       = 1024;
    localparam int MAXF       = 4;

    logic        bclk     = 1'b0;
    logic        rst      = 1'b1;
    logic        fsync    = 1'b0;
    logic        din      = 1'b0;
    logic [2:0]  fmt_sel  = 3'd0;
    logic [1:0]  wlen_sel = 2'd0;
    logic [9:0]  slot_ofs = 10'd0;
    logic [31:0] tx_data  = 32'd0;
    logic        tx_take;
    logic        dout;
    logic [31:0] rx_data;
    logic        rx_valid;

    int          n_checks = 0;
    int          n_errors = 0;
    string       cur_req  = "R1";
    logic [31:0] rxq[$];
    logic [31:0] mon_exp;

    always #(CLK_PERIOD/2) bclk = ~bclk;

    serial_audio_port dut_i (
        .bclk     (bclk),
        .rst      (rst),
        .fsync    (fsync),
        .din      (din),
        .fmt_sel  (fmt_sel),
        .wlen_sel (wlen_sel),
        .slot_ofs (slot_ofs),
        .tx_data  (tx_data),
        .tx_take  (tx_take),
        .dout     (dout),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int wl_of(input logic [1:0] c);
        case (c)
            2'd0:    return 16;
            2'd1:    return 20;
            2'd2:    return 24;
            default: return 32;
        endcase
    endfunction

    // Scoreboard monitor: pops an expected word for every strobe
    initial begin
        forever begin
            @(posedge bclk);
            #5;
            if (!rst && rx_valid) begin
                if (rxq.size() == 0) begin
                    check(1'b0, {cur_req, " R8"}, "unexpected rx word", rx_data, 32'd0);
                end else begin
                    mon_exp = rxq.pop_front();
                    check(rx_data == mon_exp, {cur_req, " R3/R4/R8"}, "rx word", rx_data, mon_exp);
                end
            end
        end
    end

    task automatic run_cfg(input logic [2:0] f_code, input logic [1:0] w_code,
                           input logic [9:0] slot, input int half, input int nfr,
                           input string req);
        logic        act;
        int          wlb;
        int          pre;
        int          total;
        int          off;
        logic        win[MAXL];
        logic        rxb[MAXL];
        int          fo[MAXL];
        logic [31:0] rw[MAXF];
        logic [31:0] tw[MAXF];
        logic [31:0] txw[MAXF];
        logic [31:0] mask;
        int          idle_bad;
        int          takes;

        cur_req  = req;
        wlb      = wl_of(w_code);
        act      = (f_code == 3'd0) || (f_code == 3'd1);
        pre      = 3;
        total    = pre + nfr * 2 * half + 40;
        idle_bad = 0;
        takes    = 0;
        mask     = (wlb == 32) ? 32'hFFFF_FFFF : ((32'h1 << wlb) - 32'h1);
        for (int g = 0; g < MAXL; g++) begin
            win[g] = 1'b0;
            rxb[g] = 1'b0;
            fo[g]  = 0;
        end
        // Expected word placement from the requirements
        for (int f = 0; f < nfr; f++) begin
            case (f_code)
                3'd0:    off = (f == 0) ? 0 : ((half >= wlb) ? half - wlb : 0);
                3'd2:    off = 1;
                3'd4:    off = int'(slot);
                default: off = 0;
            endcase
            rw[f]  = (32'h9E37_79B9 * (f + 3) ^ {f_code, 29'h0ABC_1234}) & mask;
            tw[f]  = (32'hC2B2_AE35 * (f + 5) + {30'd0, w_code}) & mask;
            txw[f] = 32'd0;
            for (int k = 0; k < wlb; k++) begin
                int g;
                g      = pre + f * 2 * half + off + k;
                win[g] = 1'b1;
                rxb[g] = rw[f][wlb-1-k];
                fo[g]  = f;
            end
        end

        fmt_sel  = f_code;
        wlen_sel = w_code;
        slot_ofs = slot;
        fsync    = !act;
        din      = 1'b0;
        rst      = 1'b1;
        repeat (3) @(posedge bclk);
        #5;
        check({rx_valid, tx_take, dout} == 3'b000, "R1", "outputs in reset",
              {29'd0, rx_valid, tx_take, dout}, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < total; i++) begin
            int rel;
            rel = i - pre;
            if (rel >= 0 && rel < nfr * 2 * half) begin
                fsync = ((rel % (2 * half)) < half) ? act : !act;
                if ((rel % (2 * half)) == 0) begin
                    tx_data = tw[rel / (2 * half)];
                    rxq.push_back(rw[rel / (2 * half)]);
                end
            end else begin
                fsync = !act;
            end
            // R10: everything outside the word is driven as ones
            din = win[i] ? rxb[i] : 1'b1;
            #(CLK_PERIOD - 8);
            if (i >= 1) begin
                if (win[i-1]) txw[fo[i-1]] = {txw[fo[i-1]][30:0], dout};
                else if (dout !== 1'b0) idle_bad++;
            end
            @(posedge bclk);
            #5;
            if (tx_take) takes++;
        end

        for (int f = 0; f < nfr; f++) begin
            check(txw[f] == tw[f], {req, " R4/R9"}, "tx word", txw[f], tw[f]);
        end
        check(idle_bad == 0, {req, " R10"}, "dout high outside word", idle_bad, 32'd0);
        check(takes == nfr, {req, " R9"}, "tx_take pulse count", takes, nfr);
        check(rxq.size() == 0, {req, " R8"}, "rx words missing", rxq.size(), 32'd0);
        rxq.delete();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        run_cfg(3'd1, 2'd0, 10'd0,  32, 2, "R2/R5 left-justified R3");
        run_cfg(3'd2, 2'd2, 10'd0,  32, 2, "R2/R5 I2S R3");
        run_cfg(3'd0, 2'd1, 10'd0,  32, 3, "R2/R6 right-justified R3");
        run_cfg(3'd3, 2'd3, 10'd0,  32, 2, "R2/R5 PCM R3");
        run_cfg(3'd4, 2'd0, 10'd40, 32, 2, "R7 slot beyond active phase");
        run_cfg(3'd4, 2'd1, 10'd0,  24, 2, "R7 slot zero");
        run_cfg(3'd0, 2'd3, 10'd0,  16, 2, "R6 slot shorter than word");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule